// File: doc/BRIEF.md
# Pipelined Streaming Quadratic Evaluator

This block takes a stream of sample pairs (x, y) and produces, for each pair, the value F = y + a·x² + b·x + c. The coefficients a, b and c are inputs that travel with each sample, so a caller may change them between samples. The arithmetic is split into three register-separated stages of roughly equal depth. The block therefore takes a new pair on every clock and returns one result per clock once it is full.

Stage one forms x·x and b·x and keeps a, c and y alongside them. Stage two forms a·x² and the partial sum b·x + c. Stage three adds the two terms and y. A valid bit runs down the same three registers. A result appears exactly three clock edges after its inputs are accepted, and an idle input cycle comes out as an idle output cycle. All values are signed two's complement. The result is wide enough that no input combination can overflow it.

Top module: `qe_top`

## Requirements
- R1: When out_valid is high, F equals y + a·x² + b·x + c, computed exactly as a signed value from the x, y, a, b and c presented with the matching accepted sample.
- R2: A sample presented with in_valid high at a rising clock edge produces out_valid high after the third rising edge from that one, which is three cycles later.
- R3: Samples presented on consecutive cycles produce results on consecutive cycles, one per clock, in the same order.
- R4: A cycle with in_valid low produces a cycle with out_valid low three cycles later, and out_valid is never high unless a sample was accepted three cycles earlier.
- R5: Each result uses the coefficients presented in the same cycle as its own x and y. A coefficient change applies only to samples that enter on or after the cycle of the change.
- R6: A synchronous active-high reset clears every valid bit. out_valid is low in the cycle after any cycle with reset high, and samples that were in flight when reset was applied produce no result.
- R7: With 16-bit inputs, F is 50 bits wide. Extreme inputs, including the most negative value -32768 on every input, give the exact result with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the valid bits |
| in_valid | input | 1 | High when x, y, a, b and c carry a sample |
| x | input | 16 | Signed sample x |
| y | input | 16 | Signed sample y |
| a | input | 16 | Signed coefficient of x² |
| b | input | 16 | Signed coefficient of x |
| c | input | 16 | Signed constant term |
| out_valid | output | 1 | High when F carries a result |
| f_out | output | 50 | Signed result F |

## Verification
The result assertion compares F against the inputs seen three edges earlier. It relies on out_valid being high only when none of the three preceding edges had reset high, which the valid chain guarantees. It also relies on the inputs being known (not X) in any cycle where in_valid is high. The bench drives every input with defined values at all times, including bubble cycles. It changes inputs only on the falling edge, so each accepted sample is stable for a full half period around the rising edge. The random stimulus spans the full signed range of every input, with bubbles and coefficient changes interleaved. Directed cases add the most negative and most positive extremes and a reset applied mid-stream.

// File: rtl/qe_pkg.sv
package qe_pkg;
    // data width of every sample and coefficient
    parameter int unsigned DW = 16;
    // product of two inputs
    localparam int unsigned PW = 2 * DW;
    // product of three inputs
    localparam int unsigned TW = 3 * DW;
    // result width: three-input product plus headroom for the additions
    localparam int unsigned FW = 3 * DW + 2;

    typedef struct packed {
        logic                 vld;
        logic signed [PW-1:0] sq;
        logic signed [PW-1:0] bx;
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] c;
        logic signed [DW-1:0] y;
    } sq_stage_t;

    typedef struct packed {
        logic                 vld;
        logic signed [TW-1:0] ax2;
        logic signed [PW:0]   bxc;
        logic signed [DW-1:0] y;
    } scale_stage_t;

    typedef struct packed {
        logic                 vld;
        logic signed [FW-1:0] f;
    } sum_stage_t;
endpackage

// File: rtl/qe_stage_sq.sv
module qe_stage_sq
    import qe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] y,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic signed [DW-1:0] c,
    output sq_stage_t            st_q
);
    sq_stage_t st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.sq = PW'(x) * PW'(x);
            st_d.bx = PW'(b) * PW'(x);
            st_d.a  = a;
            st_d.c  = c;
            st_d.y  = y;
        end
        if (rst) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R2: an accepted sample is marked valid after one edge
    p_enter_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> st_q.vld);
    // R4: a bubble stays a bubble
    p_gap_enter_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !st_q.vld);
    // R5: the coefficient held for stage two is the one presented with the sample
    p_coef_a_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (st_q.a == $past(a)) && (st_q.c == $past(c)));
endmodule

// File: rtl/qe_stage_scale.sv
module qe_stage_scale
    import qe_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  sq_stage_t    st_in,
    output scale_stage_t st_q
);
    scale_stage_t st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = st_in.vld;
        if (st_in.vld) begin
            st_d.ax2 = TW'(st_in.a) * TW'(st_in.sq);
            st_d.bxc = (PW + 1)'(st_in.bx) + (PW + 1)'(st_in.c);
            st_d.y   = st_in.y;
        end
        if (rst) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R3: a valid stage-one entry moves on with no stall
    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        st_in.vld |=> st_q.vld);
    // R4: no valid entry appears without one upstream
    p_gap_mid_r4: assert property (@(posedge clk) disable iff (rst)
        !st_in.vld |=> !st_q.vld);
    // R1: y passes through stage two unchanged
    p_y_carry_r1: assert property (@(posedge clk) disable iff (rst)
        st_in.vld |=> st_q.y == $past(st_in.y));
endmodule

// File: rtl/qe_stage_sum.sv
module qe_stage_sum
    import qe_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  scale_stage_t st_in,
    output sum_stage_t   st_q
);
    sum_stage_t st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = st_in.vld;
        if (st_in.vld) begin
            st_d.f = FW'(st_in.ax2) + FW'(st_in.bxc) + FW'(st_in.y);
        end
        if (rst) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R3: a valid stage-two entry becomes a result on the next edge
    p_finish_r3: assert property (@(posedge clk) disable iff (rst)
        st_in.vld |=> st_q.vld);
    // R4: no result without a stage-two entry
    p_gap_out_r4: assert property (@(posedge clk) disable iff (rst)
        !st_in.vld |=> !st_q.vld);
endmodule

// File: rtl/qe_top.sv
module qe_top
    import qe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] y,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic signed [DW-1:0] c,
    output logic                 out_valid,
    output logic signed [FW-1:0] f_out
);
    sq_stage_t    s1_q;
    scale_stage_t s2_q;
    sum_stage_t   s3_q;

    qe_stage_sq u_sq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x        (x),
        .y        (y),
        .a        (a),
        .b        (b),
        .c        (c),
        .st_q     (s1_q)
    );

    qe_stage_scale u_scale (
        .clk   (clk),
        .rst   (rst),
        .st_in (s1_q),
        .st_q  (s2_q)
    );

    qe_stage_sum u_sum (
        .clk   (clk),
        .rst   (rst),
        .st_in (s2_q),
        .st_q  (s3_q)
    );

    assign out_valid = s3_q.vld;
    assign f_out     = s3_q.f;

    // R1, R5, R7: result matches the inputs seen three edges earlier
    p_result_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> f_out ==
            FW'($past(y, 3))
          + FW'($past(a, 3)) * FW'($past(x, 3)) * FW'($past(x, 3))
          + FW'($past(b, 3)) * FW'($past(x, 3))
          + FW'($past(c, 3)));
    // R2: every result traces back to a sample three edges earlier
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));
    // R6: reset leaves no result in the following cycle
    p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/sim_qe_top.sv
module sim_qe_top;
    import qe_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] x = '0;
    logic signed [DW-1:0] y = '0;
    logic signed [DW-1:0] a = '0;
    logic signed [DW-1:0] b = '0;
    logic signed [DW-1:0] c = '0;
    logic                 out_valid;
    logic signed [FW-1:0] f_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    logic                 hv [3];
    logic signed [FW-1:0] hf [3];
    string                ht [3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    qe_top u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .x         (x),
        .y         (y),
        .a         (a),
        .b         (b),
        .c         (c),
        .out_valid (out_valid),
        .f_out     (f_out)
    );

    function automatic logic signed [FW-1:0] model(
        input logic signed [DW-1:0] mx, my, ma, mb, mc);
        longint t;
        t = longint'(my) + longint'(ma) * longint'(mx) * longint'(mx)
          + longint'(mb) * longint'(mx) + longint'(mc);
        return FW'(t);
    endfunction

    task automatic check_out();
        n_checks++;
        if (out_valid !== hv[2]) begin
            n_fails++;
            $display("FAIL %s out_valid actual %b expected %b", ht[2], out_valid, hv[2]);
        end else if (hv[2]) begin
            n_checks++;
            if (f_out !== hf[2]) begin
                n_fails++;
                $display("FAIL %s f_out actual %0d expected %0d", ht[2], f_out, hf[2]);
            end
        end
    endtask

    task automatic step(input logic r, input logic v,
                        input logic signed [DW-1:0] sx, sy, sa, sb, sc,
                        input string tag);
        @(negedge clk);
        check_out();
        hv[2] = hv[1]; hf[2] = hf[1]; ht[2] = ht[1];
        hv[1] = hv[0]; hf[1] = hf[0]; ht[1] = ht[0];
        rst = r; in_valid = v;
        x = sx; y = sy; a = sa; b = sb; c = sc;
        hv[0] = v; hf[0] = model(sx, sy, sa, sb, sc);
        ht[0] = v ? tag : "R4";
        if (r) begin
            for (int i = 0; i < 3; i++) begin
                hv[i] = 1'b0; ht[i] = "R6";
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; hf[i] = '0; ht[i] = "R6";
        end
        void'($urandom(32'd4242));
        // reset state (R6)
        repeat (3) step(1, 1, 16'sd5, 16'sd1, 16'sd1, 16'sd1, 16'sd1, "R6");
        // simple known value and latency (R1, R2): 7 + 2*9 + 3*3 + 4 = 38
        step(0, 1, 16'sd3, 16'sd7, 16'sd2, 16'sd3, 16'sd4, "R2");
        repeat (3) step(0, 0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, "R4");
        // back-to-back burst (R3)
        for (int i = 0; i < 6; i++)
            step(0, 1, 16'(i - 3), 16'(i * 11), 16'sd5, -16'sd7, 16'sd9, "R3");
        // coefficient change on every sample (R5)
        step(0, 1, 16'sd10, 16'sd0, 16'sd1, 16'sd0, 16'sd0, "R5");
        step(0, 1, 16'sd10, 16'sd0, -16'sd1, 16'sd2, 16'sd3, "R5");
        step(0, 1, 16'sd10, 16'sd0, 16'sd100, -16'sd50, -16'sd1, "R5");
        // extremes (R7)
        step(0, 1, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, "R7");
        step(0, 1, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, "R7");
        step(0, 1, -16'sd32768, 16'sd32767, 16'sd32767, -16'sd32768, 16'sd32767, "R7");
        step(0, 1, -16'sd32768, -16'sd32768, -16'sd32768, 16'sd32767, -16'sd32768, "R7");
        // alternate bubbles (R4)
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 16'(i * 100), 16'sd1, 16'sd2, 16'sd3, 16'sd4, "R4");
            step(0, 0, 16'sd9, 16'sd9, 16'sd9, 16'sd9, 16'sd9, "R4");
        end
        // reset with samples in flight (R6)
        step(0, 1, 16'sd1, 16'sd2, 16'sd3, 16'sd4, 16'sd5, "R6");
        step(0, 1, 16'sd6, 16'sd7, 16'sd8, 16'sd9, 16'sd10, "R6");
        step(1, 1, 16'sd11, 16'sd12, 16'sd13, 16'sd14, 16'sd15, "R6");
        repeat (3) step(0, 0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, "R6");
        // random stream (R1)
        begin
            logic signed [DW-1:0] ra, rb, rc;
            ra = 16'($urandom); rb = 16'($urandom); rc = 16'($urandom);
            for (int i = 0; i < 3000; i++) begin
                if (($urandom % 8) == 0) begin
                    ra = 16'($urandom); rb = 16'($urandom); rc = 16'($urandom);
                end
                step(0, ($urandom % 4) != 0, 16'($urandom), 16'($urandom),
                     ra, rb, rc, "R1");
            end
        end
        repeat (4) step(0, 0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, "R4");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule